// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper (Two Phases)

This block drives the on/off gate request for the two windings of a stepper motor. Each phase starts a cycle with its driver switched on. An external comparator signals through a digital trip input when the winding current has reached the threshold. On a trip, the phase's on-latch clears and the driver stays off for a fixed number of system clocks. The driver then switches on again and the cycle repeats. The off length is not global: it comes from the current-magnitude code of the phase at the moment of the trip. Smaller codes get longer off-times, spread between 7 µs and 12 µs of the system clock.

Right after each switch-on, a trip is ignored for a programmable blanking window, so that switching spikes do not end the on-time early. A trip that arrives while the driver is off has no effect. A synchronous mode input ties both phases to one shared off-time counter, so that the two choppers switch together and do not beat against each other while the motor holds position. A sleep input and an active-low reset both force the drivers off at once, whatever the latch state.

Top module: `fixed_off_chopper`

## Requirements
- R1: While `rstN` is low or `sleep` is high, `driveA` and `driveB` are 0 in the same cycle, whatever the latch state.
- R2: When the clock edge that follows the rise of `rstN` or the fall of `sleep` sees `rstN` high and `sleep` low, both drives go to 1 at that edge.
- R3: If a trip input is high at a clock edge while its phase is driving and is past blanking, that phase's drive is 0 after that edge.
- R4: After a trip, a phase stays off for exactly N clock cycles and then drives 1 again. N = 12*CLK_MHZ - floor(5*CLK_MHZ*code/(2^MAG_W-1)), where `code` is the phase's magnitude input sampled at the trip edge. Code 0 gives 12 µs and the all-ones code gives 7 µs.
- R5: For the first BLANK_CYC clock edges after a drive turns on, the trip input of that phase is ignored. A trip still high at the next edge turns the drive off.
- R6: A trip pulse during the off-time has no effect, and the off-time stays N cycles.
- R7: With `syncMode` low, a trip on one phase leaves the other phase's drive unchanged.
- R8: With `syncMode` high, a trip on either phase turns both drives off at the same edge. Both drives turn back on together after N cycles, with N taken from the tripping phase's code.
- R9: With `syncMode` high and both phases tripping at the same edge, the shared off-time is the longer of the two N values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; also gates the drives off at once |
| sleep | input | 1 | High forces both drives off and clears the chopper state |
| syncMode | input | 1 | 1: both phases share one off-time counter; 0: independent phases |
| tripA | input | 1 | Comparator trip for phase A (current reached threshold) |
| tripB | input | 1 | Comparator trip for phase B |
| magA | input | MAG_W | Current-magnitude code of phase A, selects its off-time |
| magB | input | MAG_W | Current-magnitude code of phase B |
| driveA | output | 1 | Driver enable for phase A |
| driveB | output | 1 | Driver enable for phase B |

## Verification
The bench builds the block with CLK_MHZ=2, MAG_W=3 and BLANK_CYC=3. With these values the off-times are between 14 and 24 cycles, so every off-time can be counted exactly, edge by edge, in a short run. The rounding of the off-time formula is tested at the middle codes, and its two end points are tested too. A blanking window of three edges is short enough to check each ignored edge and the first edge after it that is honoured. The shared-counter mode is tested with two codes that give clearly different lengths, so a wrong choice of source or of the longer value shows up as a count error.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Source of the value loaded into the phase-0 counter (shared in sync mode)
  typedef enum logic [1:0] {
    SRC_OWN    = 2'd0,
    SRC_OTHER  = 2'd1,
    SRC_LONGER = 2'd2
  } offSrc_e;

  // Strobes from control to datapath, one bit per phase
  typedef struct packed {
    logic       hold;
    logic [1:0] setOn;
    logic [1:0] clrOn;
    logic [1:0] loadOff;
    logic [1:0] decOff;
    logic [1:0] loadBlank;
    logic [1:0] decBlank;
    offSrc_e    srcSel;
  } chopStrobe_t;

endpackage

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int CLK_MHZ   = 10,
  parameter int MAG_W     = 3,
  parameter int BLANK_CYC = 8
) (
  input  logic             clk,
  input  chopStrobe_t      stb,
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  output logic [1:0]       latchOn,
  output logic [1:0]       offZero,
  output logic [1:0]       blankZero
);

  localparam int OFF_MAX  = 12 * CLK_MHZ;
  localparam int OFF_MIN  = 7 * CLK_MHZ;
  localparam int SPAN     = OFF_MAX - OFF_MIN;
  localparam int CODES    = 1 << MAG_W;
  localparam int TOP_CODE = CODES - 1;
  localparam int OFF_W    = $clog2(OFF_MAX + 1);
  localparam int BLK_W    = $clog2(BLANK_CYC + 1);

  // Off-time table: longest for code 0, shortest for the top code
  logic [OFF_W-1:0] offTable [CODES];
  for (genvar c = 0; c < CODES; c++) begin : g_tab
    assign offTable[c] = OFF_W'(OFF_MAX - (SPAN * c) / TOP_CODE);
  end

  logic [OFF_W-1:0] lenA, lenB, longer;
  logic [OFF_W-1:0] loadVal [2];

  assign lenA   = offTable[magA];
  assign lenB   = offTable[magB];
  assign longer = (lenA >= lenB) ? lenA : lenB;

  // Counters load N-1 so the drive is low for exactly N cycles
  always_comb begin
    case (stb.srcSel)
      SRC_OTHER:  loadVal[0] = lenB - OFF_W'(1);
      SRC_LONGER: loadVal[0] = longer - OFF_W'(1);
      default:    loadVal[0] = lenA - OFF_W'(1);
    endcase
    loadVal[1] = lenB - OFF_W'(1);
  end

  for (genvar p = 0; p < 2; p++) begin : g_phase
    logic             onQ;
    logic [OFF_W-1:0] offCnt;
    logic [BLK_W-1:0] blankCnt;

    always_ff @(posedge clk) begin
      if (stb.hold) begin
        onQ      <= 1'b0;
        offCnt   <= '0;
        blankCnt <= '0;
      end else begin
        if (stb.setOn[p])      onQ <= 1'b1;
        else if (stb.clrOn[p]) onQ <= 1'b0;

        if (stb.loadOff[p])     offCnt <= loadVal[p];
        else if (stb.decOff[p]) offCnt <= offCnt - OFF_W'(1);

        if (stb.loadBlank[p])     blankCnt <= BLK_W'(BLANK_CYC);
        else if (stb.decBlank[p]) blankCnt <= blankCnt - BLK_W'(1);
      end
    end

    assign latchOn[p]   = onQ;
    assign offZero[p]   = (offCnt == '0);
    assign blankZero[p] = (blankCnt == '0);
  end

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
(
  input  logic        rstN,
  input  logic        sleep,
  input  logic        syncMode,
  input  logic [1:0]  trip,
  input  logic [1:0]  latchOn,
  input  logic [1:0]  offZero,
  input  logic [1:0]  blankZero,
  output chopStrobe_t stb
);

  logic [1:0] fire;

  // A trip counts only while driving and past the blanking window
  assign fire = latchOn & blankZero & trip;

  always_comb begin
    stb        = '0;
    stb.srcSel = SRC_OWN;
    if (!rstN || sleep) begin
      stb.hold = 1'b1;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (latchOn[p] && !blankZero[p]) stb.decBlank[p] = 1'b1;
        if (!latchOn[p] && !offZero[p])  stb.decOff[p]   = 1'b1;
      end
      if (!syncMode) begin
        for (int p = 0; p < 2; p++) begin
          if (fire[p]) begin
            stb.clrOn[p]   = 1'b1;
            stb.loadOff[p] = 1'b1;
          end else if (!latchOn[p] && offZero[p]) begin
            stb.setOn[p]     = 1'b1;
            stb.loadBlank[p] = 1'b1;
          end
        end
      end else if (fire != 2'b00) begin
        // Shared off-time lives in the phase-0 counter
        stb.clrOn      = 2'b11;
        stb.loadOff[0] = 1'b1;
        case (fire)
          2'b11:   stb.srcSel = SRC_LONGER;
          2'b10:   stb.srcSel = SRC_OTHER;
          default: stb.srcSel = SRC_OWN;
        endcase
      end else begin
        for (int p = 0; p < 2; p++) begin
          if (!latchOn[p] && offZero[0]) begin
            stb.setOn[p]     = 1'b1;
            stb.loadBlank[p] = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/fixed_off_chopper.sv
module fixed_off_chopper
  import chop_pkg::*;
#(
  parameter int CLK_MHZ   = 10,
  parameter int MAG_W     = 3,
  parameter int BLANK_CYC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleep,
  input  logic             syncMode,
  input  logic             tripA,
  input  logic             tripB,
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  output logic             driveA,
  output logic             driveB
);

  chopStrobe_t stb;
  logic [1:0]  latchOn, offZero, blankZero;

  chop_ctrl u_ctrl (
    .rstN      (rstN),
    .sleep     (sleep),
    .syncMode  (syncMode),
    .trip      ({tripB, tripA}),
    .latchOn   (latchOn),
    .offZero   (offZero),
    .blankZero (blankZero),
    .stb       (stb)
  );

  chop_datapath #(
    .CLK_MHZ   (CLK_MHZ),
    .MAG_W     (MAG_W),
    .BLANK_CYC (BLANK_CYC)
  ) u_dp (
    .clk       (clk),
    .stb       (stb),
    .magA      (magA),
    .magB      (magB),
    .latchOn   (latchOn),
    .offZero   (offZero),
    .blankZero (blankZero)
  );

  // Sleep and reset gate the drives immediately
  assign driveA = latchOn[0] & rstN & ~sleep;
  assign driveB = latchOn[1] & rstN & ~sleep;

endmodule

// File: rtl/chopper_chk.sv
module chopper_chk (
  input logic clk,
  input logic rstN,
  input logic sleep,
  input logic syncMode,
  input logic driveA,
  input logic driveB
);

  // R1
  always_comb begin
    if (!rstN || sleep) begin
      forced_off_chk: assert (!driveA && !driveB);
    end
  end

  // R2
  property p_wake;
    @(posedge clk) disable iff (!rstN)
      ($past(!rstN) && !sleep) |=> (driveA || sleep);
  endproperty
  wake_on_chk: assert property (p_wake);

  // R4
  property p_minOff;
    @(posedge clk) disable iff (!rstN)
      ($fell(driveA) && !sleep && $past(!sleep) && $stable(syncMode)) |=> (!driveA || sleep);
  endproperty
  min_off_chk: assert property (p_minOff);

  // R5
  property p_blank;
    @(posedge clk) disable iff (!rstN)
      ($rose(driveA) && !sleep) |=> (driveA || $past(sleep) || sleep || $past(syncMode));
  endproperty
  blank_hold_chk: assert property (p_blank);

  // R8
  property p_syncOn;
    @(posedge clk) disable iff (!rstN)
      ($rose(driveA) && $past(syncMode) && !sleep && $past(!sleep)) |-> driveB;
  endproperty
  sync_on_chk: assert property (p_syncOn);

  // R8
  property p_syncOff;
    @(posedge clk) disable iff (!rstN)
      ($fell(driveA) && $past(syncMode) && !sleep && $past(!sleep)) |-> !driveB;
  endproperty
  sync_off_chk: assert property (p_syncOff);

endmodule

bind fixed_off_chopper chopper_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sleep    (sleep),
  .syncMode (syncMode),
  .driveA   (driveA),
  .driveB   (driveB)
);

// File: tb/tb_fixed_off_chopper.sv
module tb_fixed_off_chopper;

  localparam int CLK_MHZ   = 2;
  localparam int MAG_W     = 3;
  localparam int BLANK_CYC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleep = 1'b0;
  logic syncMode = 1'b0;
  logic tripA = 1'b0;
  logic tripB = 1'b0;
  logic [MAG_W-1:0] magA = '0;
  logic [MAG_W-1:0] magB = '0;
  logic driveA, driveB;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fixed_off_chopper #(
    .CLK_MHZ   (CLK_MHZ),
    .MAG_W     (MAG_W),
    .BLANK_CYC (BLANK_CYC)
  ) dut (
    .clk      (clk),
    .rstN     (rstN),
    .sleep    (sleep),
    .syncMode (syncMode),
    .tripA    (tripA),
    .tripB    (tripB),
    .magA     (magA),
    .magB     (magB),
    .driveA   (driveA),
    .driveB   (driveB)
  );

  // Expected off length from the stated formula
  function automatic int expOff(input int code);
    return 12 * CLK_MHZ - (5 * CLK_MHZ * code) / ((1 << MAG_W) - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Wait until both phases drive and are past blanking
  task automatic settle();
    for (int k = 0; k < 200 && !(driveA && driveB); k++) @(negedge clk);
    repeat (BLANK_CYC + 1) @(negedge clk);
  endtask

  // Pulse trips for one edge, count low cycles per phase
  task automatic pulseAndCount(input bit tA, input bit tB, input bit inject,
                               output int cntA, output int cntB);
    tripA = tA; tripB = tB;
    @(negedge clk);
    tripA = 1'b0; tripB = 1'b0;
    cntA = 0; cntB = 0;
    for (int k = 0; k < 200 && !(driveA && driveB); k++) begin
      if (!driveA) cntA++;
      if (!driveB) cntB++;
      if (inject && k == 2) begin
        tripA = tA; tripB = tB;
      end
      @(negedge clk);
      tripA = 1'b0; tripB = 1'b0;
    end
  endtask

  task automatic testResetAndBlank();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!driveA && !driveB, "R1 reset", {driveA, driveB}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(driveA && driveB, "R2 wake from reset", {driveA, driveB}, 3);
    tripA = 1'b1;
    for (int k = 1; k <= BLANK_CYC; k++) begin
      @(negedge clk);
      check(driveA == 1'b1, "R5 blank edge ignored", driveA, 1);
    end
    @(negedge clk);
    check(driveA == 1'b0, "R5 first edge after blank", driveA, 0);
    tripA = 1'b0;
    settle();
  endtask

  task automatic testAsyncOff(input int code);
    int cA, cB;
    magA = MAG_W'(code);
    pulseAndCount(1'b1, 1'b0, 1'b0, cA, cB);
    check(cA == expOff(code), "R4 off length", cA, expOff(code));
    check(cB == 0, "R7 other phase untouched", cB, 0);
    settle();
  endtask

  task automatic testTripDuringOff();
    int cA, cB;
    magA = 3'd5;
    pulseAndCount(1'b1, 1'b0, 1'b1, cA, cB);
    check(cA == expOff(5), "R6 trip during off ignored", cA, expOff(5));
    settle();
  endtask

  task automatic testTripB();
    int cA, cB;
    magB = 3'd2;
    tripB = 1'b1;
    @(negedge clk);
    tripB = 1'b0;
    check(driveB == 1'b0, "R3 trip turns drive off", driveB, 0);
    check(driveA == 1'b1, "R7 phase A stays on", driveA, 1);
    settle();
    pulseAndCount(1'b0, 1'b1, 1'b0, cA, cB);
    check(cB == expOff(2), "R4 phase B off length", cB, expOff(2));
    settle();
  endtask

  task automatic testSync();
    int cA, cB;
    syncMode = 1'b1;
    magA = 3'd0; magB = 3'd7;
    settle();
    pulseAndCount(1'b0, 1'b1, 1'b0, cA, cB);
    check(cA == expOff(7), "R8 sync A follows B trip", cA, expOff(7));
    check(cB == expOff(7), "R8 sync B length", cB, expOff(7));
    settle();
    magA = 3'd3;
    pulseAndCount(1'b1, 1'b0, 1'b0, cA, cB);
    check(cA == expOff(3) && cB == expOff(3), "R8 sync A trip", cB, expOff(3));
    settle();
    magA = 3'd0;
    pulseAndCount(1'b1, 1'b1, 1'b0, cA, cB);
    check(cA == expOff(0), "R9 longer wins A", cA, expOff(0));
    check(cB == expOff(0), "R9 longer wins B", cB, expOff(0));
    settle();
    syncMode = 1'b0;
    settle();
  endtask

  task automatic testSleep();
    @(negedge clk);
    sleep = 1'b1;
    #1;
    check(!driveA && !driveB, "R1 sleep immediate", {driveA, driveB}, 0);
    repeat (3) @(negedge clk);
    check(!driveA && !driveB, "R1 sleep held", {driveA, driveB}, 0);
    sleep = 1'b0;
    @(negedge clk);
    check(driveA && driveB, "R2 wake from sleep", {driveA, driveB}, 3);
    settle();
  endtask

  initial begin
    @(negedge clk);
    testResetAndBlank();
    testAsyncOff(0);
    testAsyncOff(3);
    testAsyncOff(7);
    testTripDuringOff();
    testTripB();
    testSync();
    testSleep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule